// File: doc/BRIEF.md
# Mesochronous Elastic Buffer with Delayed Start

This block moves a continuous stream of data words from one clock domain into another. Both clocks run at the same nominal frequency, but their phase relationship is unknown and drifts slowly. The block does not compare pointers and has no full or empty flag. The write side fills a 32-entry dual-port store, one word per write clock, from the first valid word onward. After a fixed wait, the write side raises a start flag.

The start flag crosses into the read domain through a two-flop synchronizer. When it arrives, it releases a read pointer that advances on every read clock. Each read cycle delivers a fresh word, so the output carries only an activity indication and no per-word valid. The distance between the two pointers is set once at start-up. This margin absorbs phase drift in either direction, as long as the fill level stays clear of both empty and full.

Top module: `meso_elastic_buf`

## Requirements
- R1: The store holds 32 words, addressed by 5-bit write and read pointers that wrap modulo 32. A stream much longer than 32 words comes out intact and in order.
- R2: Before the first word, data presented while wr_valid is low is ignored. The first word with wr_valid high is written to address 0. From then on, each wr_clk edge writes the next address, because the stream is assumed to be continuous.
- R3: The internal start flag is set on the 6th wr_clk edge after the edge that stored the first word. At that point the write pointer has reached 7. The flag stays set until wr_rst.
- R4: The start flag passes through two rd_clk flip-flops. On the following rd_clk edge, address 0 is read: rd_active rises in the same cycle that the first word appears on rd_data. At that moment between 8 and 11 words have been written.
- R5: Once rd_active is high, rd_data presents a new word on every rd_clk edge, in write order, with no gaps and no valid qualifier.
- R6: wr_rst (synchronous, active high) clears the start flag and stops writing. Within 4 rd_clk edges rd_active falls and the read pointer returns to 0. The next stream is then read out from its first word.
- R7: rd_rst (synchronous, active high) drives rd_active to 0, rd_data to 0 and the read pointer to 0.
- R8: A slow read-clock phase drift of up to 1.5 periods either way around the start-up alignment leaves the delivered data intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high write-domain reset |
| wr_valid | input | 1 | Marks the first word of the stream; ignored after it |
| wr_data | input | DATA_W | Write data, one word per wr_clk |
| rd_clk | input | 1 | Read-domain clock, same frequency as wr_clk |
| rd_rst | input | 1 | Synchronous active-high read-domain reset |
| rd_data | output | DATA_W | Registered read data |
| rd_active | output | 1 | High while rd_data carries a new word every cycle |

## Verification
The in-line properties check the following on every cycle:
- The write pointer advances by one per edge once armed.
- The start flag rises exactly when the write pointer reaches 7, and then holds.
- The read pointer advances by exactly one per cycle while running.
- The first output cycle corresponds to address 0.
- The read side falls idle, with its pointer at 0, one edge after the synchronized flag drops.

The remaining behaviours can only be shown through the bench's scenarios, where a scoreboard compares every output word with the words offered:
- that words arrive in order across pointer wraps;
- the start-up fill level;
- that the output survives a drifting read clock;
- the recovery after a write-domain reset.

// File: rtl/meso_pkg.sv
package meso_pkg;
    localparam int DEF_DATA_W      = 16;
    localparam int DEF_DEPTH       = 32;
    localparam int DEF_START_DELAY = 6;
    localparam int DEF_SYNC_STAGES = 2;

    function automatic int ptr_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction
endpackage

// File: rtl/meso_wr_ctrl.sv
module meso_wr_ctrl #(
    parameter int PTR_W       = 5,
    parameter int START_DELAY = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    output logic             we_o,
    output logic [PTR_W-1:0] waddr_o,
    output logic             start_o
);
    localparam int CNT_W = $clog2(START_DELAY + 1);

    typedef struct packed {
        logic             armed;
        logic             start;
        logic [CNT_W-1:0] cnt;
        logic [PTR_W-1:0] ptr;
    } wr_state_t;

    wr_state_t q, d;
    logic      we;

    always_comb begin
        d  = q;
        we = valid_i | q.armed;
        if (we) begin
            d.armed = 1'b1;
            d.ptr   = q.ptr + 1'b1;
        end
        if (q.armed && !q.start) begin
            if (q.cnt == CNT_W'(START_DELAY - 1)) d.start = 1'b1;
            else                                  d.cnt   = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign we_o    = we;
    assign waddr_o = q.ptr;
    assign start_o = q.start;

    assert_wptr_step_R2: assert property (@(posedge clk) disable iff (rst)
        q.armed |=> (q.ptr == PTR_W'($past(q.ptr) + 1)));

    assert_start_point_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(q.start) |-> (q.ptr == PTR_W'(START_DELAY + 1)));

    assert_start_holds_R3: assert property (@(posedge clk) disable iff (rst)
        q.start |=> q.start);
endmodule

// File: rtl/meso_sync.sv
module meso_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/meso_mem.sv
module meso_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    parameter int PTR_W  = 5
) (
    input  logic              wclk,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PTR_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we_i) store[waddr_i] <= wdata_i;
    end

    assign rdata_o = store[raddr_i];
endmodule

// File: rtl/meso_rd_ctrl.sv
module meso_rd_ctrl #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    output logic [PTR_W-1:0]  raddr_o,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              active_o
);
    typedef struct packed {
        logic              active;
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t q, d;

    always_comb begin
        d = q;
        if (go_i) begin
            d.active = 1'b1;
            d.ptr    = q.ptr + 1'b1;
            d.data   = rdata_i;
        end else begin
            d.active = 1'b0;
            d.ptr    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign raddr_o  = q.ptr;
    assign dout_o   = q.data;
    assign active_o = q.active;

    assert_no_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (q.active && go_i) |=> (q.active && q.ptr == PTR_W'($past(q.ptr) + 1)));

    assert_first_addr_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(q.active) |-> (q.ptr == PTR_W'(1)));

    assert_stop_R6: assert property (@(posedge clk) disable iff (rst)
        !go_i |=> (!q.active && q.ptr == '0));
endmodule

// File: rtl/meso_elastic_buf.sv
module meso_elastic_buf
    import meso_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int DEPTH       = DEF_DEPTH,
    parameter int START_DELAY = DEF_START_DELAY,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_active
);
    localparam int PTR_W = ptr_bits(DEPTH);

    logic             we;
    logic [PTR_W-1:0] waddr, raddr;
    logic             start_w, go_r;
    logic [DATA_W-1:0] mem_q;

    meso_wr_ctrl #(.PTR_W(PTR_W), .START_DELAY(START_DELAY)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .valid_i(wr_valid),
        .we_o(we), .waddr_o(waddr), .start_o(start_w)
    );

    meso_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
        .wclk(wr_clk), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data),
        .raddr_i(raddr), .rdata_o(mem_q)
    );

    meso_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(rd_clk), .rst(rd_rst), .d_i(start_w), .q_o(go_r)
    );

    meso_rd_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .go_i(go_r), .raddr_o(raddr),
        .rdata_i(mem_q), .dout_o(rd_data), .active_o(rd_active)
    );
endmodule

// File: tb/meso_elastic_buf_bench.sv
`timescale 1ns/100ps
module meso_elastic_buf_bench;
    localparam real PERIOD = 10.0;
    localparam int  DW     = 16;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst = 1'b1, rrst = 1'b1;
    logic          wvalid = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          ractive;

    real rhalf = PERIOD / 2.0;

    int checks = 0, fails = 0;
    logic [DW-1:0] exp_q[$];
    bit  feeding = 0, flushing = 1, seen_active = 0, done = 0;
    int  pat = 0, seq = 0, pops = 0;

    meso_elastic_buf u_meso_elastic_buf (
        .wr_clk(wclk), .wr_rst(wrst), .wr_valid(wvalid), .wr_data(wdata),
        .rd_clk(rclk), .rd_rst(rrst), .rd_data(rdata), .rd_active(ractive)
    );

    always #(PERIOD / 2.0) wclk = ~wclk;
    initial begin
        #3.0;
        forever #(rhalf) rclk = ~rclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] gen(input int p, input int s);
        case (p)
            0:       return DW'(s);
            1:       return DW'(s * 40503) ^ DW'(s >> 3);
            default: return s[0] ? 16'hAAAA : 16'h5555 ^ DW'(s);
        endcase
    endfunction

    // driver: pushes each offered word into the scoreboard queue
    always @(negedge wclk) begin
        if (feeding) begin
            wdata  = gen(pat, seq);
            wvalid = 1'b1;
            exp_q.push_back(wdata);
            seq++;
        end else begin
            wvalid = 1'b0;
            wdata  = 16'hDEAD ^ DW'(seq * 7 + 3);
        end
    end

    // monitor: pops and compares on every active read cycle
    always @(negedge rclk) begin
        if (!flushing) begin
            if (ractive) begin
                if (!seen_active) begin
                    seen_active = 1;
                    check(exp_q.size() - 1 >= 8 && exp_q.size() - 1 <= 11,
                          "R4 fill at first word", exp_q.size() - 1, 9);
                end
                if (exp_q.size() == 0) begin
                    check(0, "R5 word with empty scoreboard", rdata, 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    pops++;
                    check(rdata == e, "R5/R1 data order", rdata, e);
                end
            end else if (seen_active) begin
                check(0, "R5 gap in read stream", 0, 1);
            end
        end
    end

    task automatic restart_stream(input int p, input int idle, input int words);
        exp_q.delete();
        seen_active = 0;
        pat = p;
        seq = 0;
        flushing = 0;
        repeat (idle) @(posedge wclk);
        // R2: garbage while wr_valid low must not reach output
        check(ractive == 1'b0, "R2 idle before first word", ractive, 0);
        @(negedge wclk);
        #0.1;
        feeding = 1;
        repeat (words) @(posedge wclk);
    endtask

    initial begin
        repeat (5) @(posedge wclk);
        #1.0;
        // R7: reset state
        check(ractive == 1'b0, "R7 reset active", ractive, 0);
        check(rdata == '0, "R7 reset data", rdata, 0);
        @(negedge wclk);
        wrst = 0;
        rrst = 0;

        restart_stream(0, 8, 120);
        check(pops > 64, "R1 pointer wrap", pops, 64);

        // R8: slow phase drift of the read clock
        begin
            int p0;
            p0 = pops;
            rhalf = 5.5; repeat (15) @(posedge rclk);
            rhalf = 4.5; repeat (30) @(posedge rclk);
            rhalf = 5.5; repeat (15) @(posedge rclk);
            rhalf = PERIOD / 2.0;
            repeat (20) @(posedge wclk);
            check(pops - p0 >= 70, "R8 stream kept flowing under drift", pops - p0, 70);
        end

        // R6: write-domain reset stops the read side
        begin
            int k;
            flushing = 1;
            @(negedge wclk);
            feeding = 0;
            wrst = 1;
            @(posedge wclk);
            k = 0;
            for (int i = 0; i < 8; i++) begin
                @(posedge rclk);
                #1.0;
                k++;
                if (!ractive) break;
            end
            check(ractive == 1'b0 && k <= 4, "R6 read stop edges", k, 4);
            @(negedge wclk);
            wrst = 0;
        end
        // R6: next stream read from its first word
        restart_stream(1, 5, 80);
        check(seen_active == 1, "R6 restart after write reset", seen_active, 1);

        // R7: read reset mid-stream
        flushing = 1;
        @(negedge rclk);
        rrst = 1;
        @(posedge rclk);
        #1.0;
        check(ractive == 1'b0, "R7 read reset active", ractive, 0);
        check(rdata == '0, "R7 read reset data", rdata, 0);
        @(negedge wclk);
        feeding = 0;
        wrst = 1;
        repeat (3) @(posedge wclk);
        @(negedge wclk);
        wrst = 0;
        rrst = 0;
        restart_stream(2, 4, 60);
        check(pops > 200, "R1 total words delivered", pops, 200);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 20000.0);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule